// File: doc/BRIEF.md
# Peripheral Discovery Register Block

This block is a memory-mapped slave that lets a processor find out which peripherals a system contains, one device at a time. A fixed table of device descriptors is set by module parameters. Each descriptor holds a name length, an identifier, a base address, a region size, a first interrupt line, an interrupt count and the bytes of the device name. A private "reported" flag sits beside every entry, and a current-entry pointer with its own valid bit selects one descriptor.

Software starts a scan by writing zero to the operation register. That write raises the discovery interrupt. Software then reads the operation register over and over. Each read is a command: it retires the current entry, moves to the next entry not yet reported, and returns either an "added" code or a "done" code. The "done" code also drops the interrupt. Between steps, software reads the current entry's fields from fixed offsets. It can also write a destination address to have the block copy the entry's name, one byte per beat, through a small master write port.

Accesses that are not defined set a sticky error flag. They leave the scan state unchanged, and reads of this kind return zero.

Top module: `dev_enum_top`

## Requirements
- R1: After reset, `irq_o`, `err_o`, `mst_valid` and `rsp_valid` are 0, `req_ready` is 1 and no entry is current, so every field read returns 0.
- R2: Writing the value 0 to offset 0x00 clears all reported flags and the current entry, and sets `irq_o` to 1 from the cycle after the access.
- R3: Reading offset 0x00 with no current entry selects the lowest-indexed unreported entry and returns 0x08 when one exists.
- R4: Reading offset 0x00 with a current entry first marks that entry reported, then selects the next unreported entry above it and returns 0x08. Reported entries are skipped, so a read after a finished scan returns 0x00 until the next scan start.
- R5: When a read of offset 0x00 finds no unreported entry, it returns 0x00, leaves no entry current and drives `irq_o` to 0.
- R6: With an entry current, reads return that entry's fields zero-extended to 32 bits: name length at 0x08, identifier at 0x0C, base address at 0x10, region size at 0x14, first interrupt at 0x18 and interrupt count at 0x1C.
- R7: With no entry current, reads of offsets 0x08 to 0x1C return 0.
- R8: Writing address A to offset 0x04 with an entry current issues one master beat for each name byte, up to the entry's name length (at most NAME_MAX, and none for length 0). Beat k carries address A+k and name byte k. A beat's address and data hold steady while `mst_ready` is low.
- R9: Writing offset 0x04 with no entry current produces no master beat.
- R10: `req_ready` is low from the cycle after a name-copy write until the last byte has been accepted, so all register accesses wait for the copy.
- R11: A nonzero write to 0x00, a write to any offset other than 0x00 or 0x04, and a read of 0x04 or of any offset outside 0x00 and 0x08 to 0x1C set `err_o`. `err_o` then stays set until reset. Such an access returns 0 and changes neither the current entry, the reported flags nor `irq_o`.
- R12: Every accepted access produces a one-cycle `rsp_valid` in the next cycle, with the read data in `rsp_rdata` (0 for writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| err_o | output | 1 | Sticky access error flag |
| irq_o | output | 1 | High while a scan has devices left to report |
| mst_valid | output | 1 | Name byte write request |
| mst_ready | input | 1 | Name byte write accepted |
| mst_addr | output | 32 | Byte address of the name write |
| mst_data | output | 8 | Name byte |

## Verification
On every cycle, assertions check four things. The current entry is never one already marked reported. A scan start leaves a clean state with the interrupt raised. An exhausted step leaves the interrupt low. A bad access freezes the scan state. Assertions also check that master beats hold while stalled, that the slave is stalled during a copy, that the error flag is sticky and that each response follows an acceptance. Only the bench scenarios can show the rest: the order in which entries are visited, the field values and codes returned, the skipping of reported entries after a finished scan, and the exact byte sequence and addresses of a name copy. The bench checks these against a model driven by seeded random accesses mixed with directed corner cases.

// File: rtl/dev_enum_pkg.sv
package dev_enum_pkg;
  // register offsets; software decodes these
  localparam int OFF_OP    = 'h00;
  localparam int OFF_DST   = 'h04;
  localparam int OFF_NLEN  = 'h08;
  localparam int OFF_ID    = 'h0C;
  localparam int OFF_BASE  = 'h10;
  localparam int OFF_SIZE  = 'h14;
  localparam int OFF_IRQ   = 'h18;
  localparam int OFF_IRQN  = 'h1C;

  localparam logic [31:0] CODE_ADDED = 32'h0000_0008;
  localparam logic [31:0] CODE_DONE  = 32'h0000_0000;
endpackage

// File: rtl/dev_enum_rst_sync.sv
module dev_enum_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dev_enum_scan.sv
module dev_enum_scan #(
  parameter int N_DEV = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          step_i,
  output logic          found_o,
  output logic          cur_vld_o,
  output logic [IW-1:0] cur_idx_o,
  output logic          irq_o
);
  logic [N_DEV-1:0] reported_q, reported_d, rep_base;
  logic             cur_vld_q, cur_vld_d;
  logic [IW-1:0]    cur_idx_q, cur_idx_d, nxt_idx;
  logic             irq_q, irq_d;
  logic             found;
  int               start_pos;

  // candidate search: lowest unreported entry at or above start_pos
  always_comb begin
    rep_base = reported_q;
    if (cur_vld_q) rep_base[cur_idx_q] = 1'b1;
    start_pos = cur_vld_q ? int'(cur_idx_q) + 1 : 0;
    found   = 1'b0;
    nxt_idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (!rep_base[i] && i >= start_pos) begin
        found   = 1'b1;
        nxt_idx = IW'(i);
      end
    end
  end

  always_comb begin
    reported_d = reported_q;
    cur_vld_d  = cur_vld_q;
    cur_idx_d  = cur_idx_q;
    irq_d      = irq_q;
    if (init_i) begin
      reported_d = '0;
      cur_vld_d  = 1'b0;
      cur_idx_d  = '0;
      irq_d      = 1'b1;
    end else if (step_i) begin
      reported_d = rep_base;
      cur_vld_d  = found;
      cur_idx_d  = found ? nxt_idx : '0;
      if (!found) irq_d = 1'b0;
    end
  end

  logic scan_en;
  assign scan_en = init_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reported_q <= '0;
      cur_vld_q  <= 1'b0;
      cur_idx_q  <= '0;
      irq_q      <= 1'b0;
    end else if (scan_en) begin
      reported_q <= reported_d;
      cur_vld_q  <= cur_vld_d;
      cur_idx_q  <= cur_idx_d;
      irq_q      <= irq_d;
    end
  end

  assign found_o   = found;
  assign cur_vld_o = cur_vld_q;
  assign cur_idx_o = cur_idx_q;
  assign irq_o     = irq_q;

  assert_cur_unreported_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld_q |-> !reported_q[cur_idx_q]);

  assert_init_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (irq_q && !cur_vld_q && reported_q == '0));

  assert_done_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i && !found) |=> (!irq_q && !cur_vld_q));
endmodule

// File: rtl/dev_enum_copy.sv
module dev_enum_copy #(
  parameter int N_DEV    = 4,
  parameter int NAME_MAX = 8,
  parameter int IW       = 2,
  parameter logic [N_DEV*8-1:0]          T_LEN  = '0,
  parameter logic [N_DEV*NAME_MAX*8-1:0] T_NAME = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [IW-1:0] idx_i,
  input  logic [31:0]   dst_i,
  output logic          busy_o,
  output logic          mst_valid,
  input  logic          mst_ready,
  output logic [31:0]   mst_addr,
  output logic [7:0]    mst_data
);
  localparam int CW = $clog2(NAME_MAX + 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [7:0]    raw_len;
  logic [CW-1:0] req_len;
  logic          eng_en;

  always_comb begin
    raw_len = T_LEN[int'(idx_i)*8 +: 8];
    req_len = (int'(raw_len) > NAME_MAX) ? CW'(NAME_MAX) : CW'(raw_len);
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (start_i && !busy_q) begin
      busy_d = (req_len != '0);
      idx_d  = idx_i;
      dst_d  = dst_i;
      cnt_d  = '0;
      len_d  = req_len;
    end else if (busy_q && mst_ready) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q + 1'b1 == len_q) busy_d = 1'b0;
    end
  end

  assign eng_en = (start_i && !busy_q) || (busy_q && mst_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (eng_en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  assign busy_o    = busy_q;
  assign mst_valid = busy_q;
  assign mst_addr  = dst_q + 32'(cnt_q);
  assign mst_data  = T_NAME[(int'(idx_q)*NAME_MAX + int'(cnt_q))*8 +: 8];

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && !mst_ready) |=> (mst_valid && $stable(mst_addr) && $stable(mst_data)));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));
endmodule

// File: rtl/dev_enum_top.sv
module dev_enum_top
  import dev_enum_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int NAME_MAX = 8,
  parameter int AW       = 8,
  parameter logic [N_DEV*8-1:0]          T_LEN  = {8'd2, 8'd4, 8'd8, 8'd3},
  parameter logic [N_DEV*32-1:0]         T_ID   = {32'h14, 32'h13, 32'h12, 32'h11},
  parameter logic [N_DEV*32-1:0]         T_BASE = {32'h1000_4000, 32'h1000_3000, 32'h1000_2000, 32'h1000_1000},
  parameter logic [N_DEV*32-1:0]         T_SIZE = {32'h1000, 32'h1000, 32'h1000, 32'h1000},
  parameter logic [N_DEV*32-1:0]         T_IRQ  = {32'd7, 32'd5, 32'd4, 32'd2},
  parameter logic [N_DEV*32-1:0]         T_IRQN = {32'd1, 32'd1, 32'd1, 32'd2},
  parameter logic [N_DEV*NAME_MAX*8-1:0] T_NAME = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          err_o,
  output logic          irq_o,
  output logic          mst_valid,
  input  logic          mst_ready,
  output logic [31:0]   mst_addr,
  output logic [7:0]    mst_data
);
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam logic [AW-1:0] A_OP   = AW'(OFF_OP);
  localparam logic [AW-1:0] A_DST  = AW'(OFF_DST);
  localparam logic [AW-1:0] A_NLEN = AW'(OFF_NLEN);
  localparam logic [AW-1:0] A_ID   = AW'(OFF_ID);
  localparam logic [AW-1:0] A_BASE = AW'(OFF_BASE);
  localparam logic [AW-1:0] A_SIZE = AW'(OFF_SIZE);
  localparam logic [AW-1:0] A_IRQ  = AW'(OFF_IRQ);
  localparam logic [AW-1:0] A_IRQN = AW'(OFF_IRQN);

  logic          srst_n;
  logic          acc, init_go, step_go, copy_go, bad_acc;
  logic          rd_ok, wr_ok;
  logic [31:0]   rd_data;
  logic          found, cur_vld, copy_busy;
  logic [IW-1:0] cur_idx;

  dev_enum_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign req_ready = !copy_busy;
  assign acc       = req_valid && req_ready;

  // write decode
  assign wr_ok   = (req_addr == A_OP && req_wdata == 32'h0) || (req_addr == A_DST);
  assign init_go = acc &&  req_write && req_addr == A_OP && req_wdata == 32'h0;
  assign step_go = acc && !req_write && req_addr == A_OP;
  assign copy_go = acc &&  req_write && req_addr == A_DST && cur_vld;

  // read mux over the current descriptor
  always_comb begin
    rd_ok   = 1'b1;
    rd_data = 32'h0;
    case (req_addr)
      A_OP:    rd_data = found ? CODE_ADDED : CODE_DONE;
      A_NLEN:  rd_data = cur_vld ? {24'h0, T_LEN[int'(cur_idx)*8 +: 8]} : 32'h0;
      A_ID:    rd_data = cur_vld ? T_ID  [int'(cur_idx)*32 +: 32] : 32'h0;
      A_BASE:  rd_data = cur_vld ? T_BASE[int'(cur_idx)*32 +: 32] : 32'h0;
      A_SIZE:  rd_data = cur_vld ? T_SIZE[int'(cur_idx)*32 +: 32] : 32'h0;
      A_IRQ:   rd_data = cur_vld ? T_IRQ [int'(cur_idx)*32 +: 32] : 32'h0;
      A_IRQN:  rd_data = cur_vld ? T_IRQN[int'(cur_idx)*32 +: 32] : 32'h0;
      default: rd_ok   = 1'b0;
    endcase
  end

  assign bad_acc = acc && (req_write ? !wr_ok : !rd_ok);

  dev_enum_scan #(
    .N_DEV (N_DEV),
    .IW    (IW)
  ) u_scan (
    .clk       (clk),
    .rst_n     (srst_n),
    .init_i    (init_go),
    .step_i    (step_go),
    .found_o   (found),
    .cur_vld_o (cur_vld),
    .cur_idx_o (cur_idx),
    .irq_o     (irq_o)
  );

  dev_enum_copy #(
    .N_DEV    (N_DEV),
    .NAME_MAX (NAME_MAX),
    .IW       (IW),
    .T_LEN    (T_LEN),
    .T_NAME   (T_NAME)
  ) u_copy (
    .clk       (clk),
    .rst_n     (srst_n),
    .start_i   (copy_go),
    .idx_i     (cur_idx),
    .dst_i     (req_wdata),
    .busy_o    (copy_busy),
    .mst_valid (mst_valid),
    .mst_ready (mst_ready),
    .mst_addr  (mst_addr),
    .mst_data  (mst_data)
  );

  // response and error registers
  logic        rsp_valid_q, rsp_valid_d;
  logic [31:0] rsp_rdata_q, rsp_rdata_d;
  logic        err_q, err_d;

  always_comb begin
    rsp_valid_d = acc;
    rsp_rdata_d = (!req_write && rd_ok) ? rd_data : 32'h0;
    err_d       = err_q | bad_acc;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= 32'h0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (acc) rsp_rdata_q <= rsp_rdata_d;
      if (bad_acc) err_q <= err_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign err_o     = err_q;

  assert_copy_stalls_R10: assert property (@(posedge clk) disable iff (!srst_n)
    mst_valid |-> !req_ready);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!srst_n)
    err_q |=> err_q);

  assert_bad_frozen_R11: assert property (@(posedge clk) disable iff (!srst_n)
    bad_acc |=> ($stable(cur_vld) && $stable(cur_idx) && $stable(irq_o)));

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |-> $past(req_valid && req_ready));
endmodule

// File: tb/dev_enum_top_bench.sv
module dev_enum_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NM = 8;
  localparam int AW = 8;

  function automatic int e_len(int i);
    case (i)
      0: return 3;
      1: return 8;
      2: return 0;
      default: return 5;
    endcase
  endfunction

  function automatic logic [7:0] e_byte(int i, int k);
    return 8'(8'h40 + i*16 + k);
  endfunction

  // sel: 0 id, 1 base, 2 size, 3 first irq, 4 irq count
  function automatic logic [31:0] e_f32(int sel, int i);
    case (sel)
      0: return 32'h0100 + 32'(i);
      1: return 32'h1000_0000 + 32'(i) * 32'h1000;
      2: return 32'h40 << i;
      3: return 32'(3 + 2*i);
      default: return 32'(i % 3);
    endcase
  endfunction

  function automatic logic [N*8-1:0] pk_len();
    logic [N*8-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'(e_len(i));
    return v;
  endfunction

  function automatic logic [N*32-1:0] pk32(int sel);
    logic [N*32-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[i*32 +: 32] = e_f32(sel, i);
    return v;
  endfunction

  function automatic logic [N*NM*8-1:0] pk_name();
    logic [N*NM*8-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < NM; k++) v[(i*NM + k)*8 +: 8] = e_byte(i, k);
    return v;
  endfunction

  localparam logic [N*8-1:0]    P_LEN  = pk_len();
  localparam logic [N*32-1:0]   P_ID   = pk32(0);
  localparam logic [N*32-1:0]   P_BASE = pk32(1);
  localparam logic [N*32-1:0]   P_SIZE = pk32(2);
  localparam logic [N*32-1:0]   P_IRQ  = pk32(3);
  localparam logic [N*32-1:0]   P_IRQN = pk32(4);
  localparam logic [N*NM*8-1:0] P_NAME = pk_name();

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          err_o, irq_o;
  logic          mst_valid, mst_ready;
  logic [31:0]   mst_addr;
  logic [7:0]    mst_data;

  dev_enum_top #(
    .N_DEV (N), .NAME_MAX (NM), .AW (AW),
    .T_LEN (P_LEN), .T_ID (P_ID), .T_BASE (P_BASE), .T_SIZE (P_SIZE),
    .T_IRQ (P_IRQ), .T_IRQN (P_IRQN), .T_NAME (P_NAME)
  ) u_dev_enum_top (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .err_o (err_o), .irq_o (irq_o),
    .mst_valid (mst_valid), .mst_ready (mst_ready),
    .mst_addr (mst_addr), .mst_data (mst_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_total = 0;
  int  n_bad   = 0;
  bit  finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // master port responder and beat capture
  logic [31:0] cap_addr [0:1023];
  logic [7:0]  cap_data [0:1023];
  int          cap_n = 0;
  bit          stall_all = 0;

  initial mst_ready = 1'b0;
  always @(negedge clk) begin
    logic r;
    r = stall_all ? 1'b0 : (($urandom % 10) < 7);
    mst_ready = r;
    if (mst_valid && r && cap_n < 1024) begin
      cap_addr[cap_n] = mst_addr;
      cap_data[cap_n] = mst_data;
      cap_n++;
    end
  end

  // reference model
  bit m_rep [N];
  bit m_vld;
  int m_cur;
  bit m_irq;
  bit m_err;

  task automatic m_init();
    for (int i = 0; i < N; i++) m_rep[i] = 0;
    m_vld = 0; m_cur = 0; m_irq = 1;
  endtask

  task automatic m_step(output logic [31:0] code);
    int st;
    if (m_vld) begin m_rep[m_cur] = 1; st = m_cur + 1; end
    else st = 0;
    m_vld = 0;
    for (int i = st; i < N; i++)
      if (!m_vld && !m_rep[i]) begin m_vld = 1; m_cur = i; end
    if (m_vld) code = 32'h8;
    else begin code = 32'h0; m_irq = 0; end
  endtask

  function automatic logic [31:0] m_field(int off);
    if (!m_vld) return 32'h0;
    case (off)
      'h08: return 32'(e_len(m_cur));
      'h0C: return e_f32(0, m_cur);
      'h10: return e_f32(1, m_cur);
      'h14: return e_f32(2, m_cur);
      'h18: return e_f32(3, m_cur);
      default: return e_f32(4, m_cur);
    endcase
  endfunction

  // one register access; returns at the negedge after acceptance
  task automatic access(input bit wr, input int off, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(off); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R12 rsp_valid", 32'(rsp_valid), 32'h1);
    rd = rsp_rdata;
  endtask

  task automatic do_step(input string req);
    logic [31:0] rd, ex;
    access(0, 'h00, 32'h0, rd);
    m_step(ex);
    chk(req, rd, ex);
    chk("R5 irq", 32'(irq_o), 32'(m_irq));
  endtask

  task automatic do_field(input int off, input string req);
    logic [31:0] rd;
    access(0, off, 32'h0, rd);
    chk(req, rd, m_field(off));
  endtask

  task automatic do_init();
    logic [31:0] rd;
    access(1, 'h00, 32'h0, rd);
    m_init();
    chk("R2 irq after start", 32'(irq_o), 32'h1);
    chk("R12 write data zero", rd, 32'h0);
  endtask

  task automatic do_copy(input logic [31:0] dst);
    logic [31:0] rd;
    int base_n, len;
    base_n = cap_n;
    len = m_vld ? e_len(m_cur) : 0;
    access(1, 'h04, dst, rd);
    if (len > 0) chk("R10 ready low during copy", 32'(req_ready), 32'h0);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    if (m_vld) begin
      chk("R8 beat count", 32'(cap_n - base_n), 32'(len));
      for (int k = 0; k < len; k++) begin
        chk("R8 beat addr", cap_addr[base_n + k], dst + 32'(k));
        chk("R8 beat data", 32'(cap_data[base_n + k]), 32'(e_byte(m_cur, k)));
      end
    end else begin
      chk("R9 no beats without entry", 32'(cap_n - base_n), 32'h0);
    end
  endtask

  task automatic do_bad(input int kind);
    logic [31:0] rd;
    case (kind)
      0: access(1, 'h00, 32'h0000_0001 + ($urandom % 100), rd);
      1: access(1, 'h08 + 4*($urandom % 6), 32'h5, rd);
      2: access(0, 'h04, 32'h0, rd);
      default: access(0, 'h20 + ($urandom % 8), 32'h0, rd);
    endcase
    m_err = 1;
    if (kind >= 2) chk("R11 bad read returns zero", rd, 32'h0);
    chk("R11 err set", 32'(err_o), 32'h1);
    chk("R11 irq unchanged", 32'(irq_o), 32'(m_irq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_rep[i] = 0;
    m_vld = 0; m_cur = 0; m_irq = 0; m_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 err", 32'(err_o), 32'h0);
    chk("R1 ready", 32'(req_ready), 32'h1);
    chk("R1 mst_valid", 32'(mst_valid), 32'h0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    do_field('h0C, "R1 field after reset");
    do_field('h08, "R7 field no current");
    do_copy(32'h2000_0000);

    // R2, R3, R6: full scan
    do_init();
    do_field('h10, "R7 field after start");
    do_step("R3 first step");
    for (int off = 'h08; off <= 'h1C; off += 4) do_field(off, "R6 fields entry 0");
    do_copy(32'h3000_0010);
    // field read issued right behind a copy waits for it (R10)
    stall_all = 1;
    access(1, 'h04, 32'h3000_0100, rd);
    chk("R10 ready low while master stalled", 32'(req_ready), 32'h0);
    repeat (5) @(negedge clk);
    chk("R8 hold addr", mst_addr, 32'h3000_0100);
    chk("R8 hold data", 32'(mst_data), 32'(e_byte(0, 0)));
    stall_all = 0;
    while (!req_ready) @(negedge clk);
    do_field('h08, "R10 read after copy");
    for (int s = 0; s < N; s++) begin
      do_step("R4 step");
      for (int off = 'h08; off <= 'h1C; off += 4) do_field(off, "R6 fields");
      if (m_vld) do_copy(32'h4000_0000 + 32'(s) * 32'h100);
    end
    chk("R5 irq low when done", 32'(irq_o), 32'h0);
    do_field('h0C, "R7 field after done");
    do_step("R4 reported entries skipped after done");
    do_copy(32'h5000_0000);

    // R2 restart mid-scan
    do_init();
    do_step("R3 restart");
    do_step("R4 second");
    do_init();
    do_step("R2 start clears reported");
    do_field('h0C, "R2 entry 0 again");
    do_step("R4 advance");

    // R11 bad accesses freeze the scan
    for (int k = 0; k < 4; k++) begin
      do_bad(k);
      do_field('h0C, "R11 scan state unchanged");
    end
    do_step("R11 step after errors");

    // seeded random traffic
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = $urandom % 100;
      if (sel < 8)       do_init();
      else if (sel < 45) do_step("R4 random step");
      else if (sel < 78) do_field('h08 + 4*($urandom % 6), "R6 random field");
      else if (sel < 90) do_copy($urandom);
      else               do_bad($urandom % 4);
      chk("R11 err sticky", 32'(err_o), 32'(m_err));
      chk("R2 irq model", 32'(irq_o), 32'(m_irq));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule